// File: doc/BRIEF.md
# YCbCr 4:2:2 to 4:4:4 Pixel Formatter

This block takes a 16-bit video word stream in which each word holds one luma value and one chroma value, with the chroma alternating Cb, Cr, Cb, Cr. It registers each word on the pixel clock. For every luma value it produces one 24-bit sample that carries Y, Cb and Cr together. The two luma values of a pair share the Cb of the first word and the Cr of the second. No filtering or interpolation is applied: chroma is copied to both samples of the pair.

A start-of-line marker arrives with the first word of each line. It forces that word to be read as a Cb word. The first sample of a pair is held until its Cr word arrives. The two samples then leave on consecutive cycles. A pair left half-finished when a line ends is flushed when the next line starts. The flushed sample uses the most recent Cr seen.

Top module: `ycc422_to_444`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid and out_data are cleared on that edge. After reset, the first valid word is read as a Cb word, and the stored last Cr value is 8'h80.
- R2: In each input word, luma sits in bits [15:8] and chroma in bits [7:0]. Each output sample holds Y in [23:16], Cb in [15:8] and Cr in [7:0].
- R3: Valid words alternate between Cb words and Cr words, starting with a Cb word. A valid word with in_sol high is always read as a Cb word.
- R4: A Cb word and the Cr word that follows it produce two samples, in luma order. Both samples carry that Cb and that Cr.
- R5: Take a Cr word sampled at clock edge k. Its pair's first sample is on the output after edge k+1 and its second sample after edge k+2, each with out_valid high for one cycle.
- R6: A valid word with in_sol high may arrive while a Cb word is still waiting for its Cr. In that case the waiting sample is emitted after the edge following the one that sampled in_sol. It uses the most recent Cr received, or 8'h80 if no Cr has been received since reset.
- R7: Words presented with in_valid low have no effect on the output values, the output timing or the Cb/Cr phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_sol | input | 1 | Start of line, high with the first word of a line |
| in_data | input | 16 | Luma [15:8], chroma [7:0] |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 24 | Y [23:16], Cb [15:8], Cr [7:0] |

## Verification
The embedded assertions check four things on every cycle. The input register captures each valid word. A start-of-line word always leaves the formatter expecting a Cr word next. The second sample of a pair always follows the first on the next cycle and carries the same chroma. An output is never produced without a valid word or a pending second sample behind it. The exact sample contents and the exact output cycle can only be shown by the scoreboard scenarios. The same holds for the flush of an unpaired word, including the 8'h80 default, and for the neutrality of idle words carrying changing data. The scoreboard computes each expected sample and its due cycle independently of the design.

// File: rtl/ycc_fmt_pkg.sv
// Shared constants for the 4:2:2 to 4:4:4 formatter.
// Assumes 8-bit components unless a module overrides its parameter.
package ycc_fmt_pkg;
    localparam int COMP_W      = 8;
    localparam int NEUTRAL_C   = 128;   // mid-scale chroma used before any Cr
endpackage

// File: rtl/ycc_word_reg.sv
// Input register: captures the 4:2:2 word, its valid and its start-of-line
// flag on the pixel clock edge. Assumes the inputs are synchronous to clk.
module ycc_word_reg #(
    parameter int COMP_W = ycc_fmt_pkg::COMP_W,
    localparam int WORD_W = 2 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_valid,
    input  logic              d_sol,
    input  logic [WORD_W-1:0] d_word,
    output logic              q_valid,
    output logic              q_sol,
    output logic [WORD_W-1:0] q_word
);
    // Capture the incoming word every cycle; qualifiers clear in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_sol   <= 1'b0;
            q_word  <= '0;
        end else begin
            q_valid <= d_valid;
            q_sol   <= d_valid & d_sol;
            q_word  <= d_word;
        end
    end

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |=> (q_valid && q_word == $past(d_word)));
    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !d_valid |=> (!q_valid && !q_sol));
endmodule

// File: rtl/ycc_pair_fmt.sv
// Pair formatter: holds the luma of a Cb word until the matching Cr word,
// then emits two full samples on consecutive cycles. A start-of-line word
// forces the Cb phase and flushes any waiting sample using the last Cr.
// Assumes no more than one valid word per cycle.
module ycc_pair_fmt #(
    parameter int COMP_W    = ycc_fmt_pkg::COMP_W,
    parameter int NEUTRAL_C = ycc_fmt_pkg::NEUTRAL_C,
    localparam int WORD_W   = 2 * COMP_W,
    localparam int SAMP_W   = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w_valid,
    input  logic              w_sol,
    input  logic [WORD_W-1:0] w_word,
    output logic              s_valid,
    output logic [SAMP_W-1:0] s_data
);
    logic              want_cr;     // 1: next word is a Cr word
    logic [COMP_W-1:0] y_first;
    logic [COMP_W-1:0] y_second;
    logic [COMP_W-1:0] cb_hold;
    logic [COMP_W-1:0] cr_last;
    logic              second_due;

    logic [COMP_W-1:0] w_y;
    logic [COMP_W-1:0] w_c;
    logic              is_cb_word;

    // Split the word and decide its role.
    always_comb begin
        w_y        = w_word[WORD_W-1:COMP_W];
        w_c        = w_word[COMP_W-1:0];
        is_cb_word = w_sol | ~want_cr;
    end

    // Phase tracking, chroma storage and output sample generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_cr    <= 1'b0;
            y_first    <= '0;
            y_second   <= '0;
            cb_hold    <= '0;
            cr_last    <= COMP_W'(NEUTRAL_C);
            second_due <= 1'b0;
            s_valid    <= 1'b0;
            s_data     <= '0;
        end else begin
            s_valid    <= 1'b0;
            second_due <= 1'b0;
            if (second_due) begin
                s_valid <= 1'b1;
                s_data  <= {y_second, cb_hold, cr_last};
            end
            if (w_valid) begin
                if (is_cb_word) begin
                    if (want_cr) begin
                        s_valid <= 1'b1;
                        s_data  <= {y_first, cb_hold, cr_last};
                    end
                    y_first <= w_y;
                    cb_hold <= w_c;
                    want_cr <= 1'b1;
                end else begin
                    s_valid    <= 1'b1;
                    s_data     <= {y_first, cb_hold, w_c};
                    cr_last    <= w_c;
                    y_second   <= w_y;
                    second_due <= 1'b1;
                    want_cr    <= 1'b0;
                end
            end
        end
    end

    assert_sol_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && w_sol) |=> want_cr);
    assert_pair_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
        second_due |-> s_valid);
    assert_pair_chroma_R4: assert property (@(posedge clk) disable iff (!rst_n)
        second_due |=> (s_valid && s_data[2*COMP_W-1:0] == $past(s_data[2*COMP_W-1:0])));
    assert_out_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid |-> $past(w_valid || second_due));
endmodule

// File: rtl/ycc422_to_444.sv
// Top: 4:2:2 word stream in, one 4:4:4 sample per luma out.
// Input register followed by the pair formatter; latency as in the brief.
module ycc422_to_444 #(
    parameter int COMP_W = ycc_fmt_pkg::COMP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_sol,
    input  logic [2*COMP_W-1:0] in_data,
    output logic                out_valid,
    output logic [3*COMP_W-1:0] out_data
);
    logic                r_valid;
    logic                r_sol;
    logic [2*COMP_W-1:0] r_word;

    ycc_word_reg #(.COMP_W(COMP_W)) u_in (
        .clk(clk), .rst_n(rst_n),
        .d_valid(in_valid), .d_sol(in_sol), .d_word(in_data),
        .q_valid(r_valid), .q_sol(r_sol), .q_word(r_word)
    );

    ycc_pair_fmt #(.COMP_W(COMP_W)) u_fmt (
        .clk(clk), .rst_n(rst_n),
        .w_valid(r_valid), .w_sol(r_sol), .w_word(r_word),
        .s_valid(out_valid), .s_data(out_data)
    );

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));
endmodule

// File: tb/ycc422_to_444_test.sv
module ycc422_to_444_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sol = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [23:0] out_data;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    logic [23:0] exp_q[$];
    int          due_q[$];
    string       tag_q[$];

    // model state
    bit       m_want_cr = 0;
    bit [7:0] m_y0 = 0, m_cb = 0, m_cr = 8'h80;

    ycc422_to_444 uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [23:0] d, input int due, input string tag);
        exp_q.push_back(d);
        due_q.push_back(due);
        tag_q.push_back(tag);
    endtask

    // Driver: presents one valid word; model predicts samples and due cycles.
    task automatic word(input bit sol, input logic [7:0] y, input logic [7:0] c);
        @(negedge clk);
        in_valid = 1'b1; in_sol = sol; in_data = {y, c};
        if (sol || !m_want_cr) begin
            if (m_want_cr) push({m_y0, m_cb, m_cr}, cyc + 2, "R6");
            m_y0 = y; m_cb = c; m_want_cr = 1;
        end else begin
            m_cr = c;
            push({m_y0, m_cb, c}, cyc + 2, "R4");
            push({y, m_cb, c}, cyc + 3, "R5");
            m_want_cr = 0;
        end
    endtask

    // Idle cycles with changing junk data (R7).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sol = 1'b1; in_data = 16'hDEAD ^ 16'(i * 16'h1357);
        end
    endtask

    // Monitor: compare outputs against the scoreboard away from the edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected output", {8'h0, out_data}, 32'hFFFFFFFF);
            end else begin
                automatic logic [23:0] e = exp_q.pop_front();
                automatic int d = due_q.pop_front();
                automatic string t = tag_q.pop_front();
                check({t, " R2 data"}, {8'h0, out_data}, {8'h0, e});
                check({t, " R5 cycle"}, cyc, d);
            end
        end else if (rst_n && exp_q.size() != 0 && due_q[0] < cyc) begin
            check({tag_q[0], " missing output"}, cyc, due_q[0]);
            void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
        end
    end

    initial begin : watchdog
        #(5 * 20000);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        in_valid = 1'b1; in_data = 16'h1234;       // activity during reset
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {31'h0, out_valid}, 32'h0);
        check("R1 data in reset", {8'h0, out_data}, 32'h0);
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;
        idle(2);
        check("R1 idle after reset", {31'h0, out_valid}, 32'h0);

        // R6 with default Cr 8'h80: unpaired first line of one word
        word(1, 8'h10, 8'h20);
        idle(2);
        word(1, 8'h30, 8'h40);   // flush with 0x80
        word(0, 8'h31, 8'h50);
        // back-to-back line (R3 R4 R5)
        word(1, 8'hA0, 8'h11);
        word(0, 8'hA1, 8'h22);
        word(0, 8'hA2, 8'h33);
        word(0, 8'hA3, 8'h44);
        word(0, 8'hA4, 8'h55);   // unpaired
        // next line flushes with last Cr 0x44 (R6)
        word(1, 8'hB0, 8'h66);
        idle(3);                 // gaps with junk (R7)
        word(0, 8'hB1, 8'h77);
        idle(1);
        word(0, 8'hB2, 8'h88);
        idle(2);
        word(0, 8'hB3, 8'h99);
        // SOL while balanced: no flush (R3)
        word(1, 8'hC0, 8'h01);
        word(0, 8'hC1, 8'h02);
        for (int i = 0; i < 40; i++) word(0, 8'(i), 8'(i * 3 + 1));
        idle(6);
        check("R7 scoreboard drained", exp_q.size(), 0);
        check("R3 final phase balanced", {31'h0, m_want_cr}, 32'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule